// File: doc/BRIEF.md
# Translation Lookaside Buffer with Access Protection

This block caches recent page translations for a 32-bit virtual, 28-bit physical address space with 8 KB pages. It sits beside the first-level cache. A lookup is answered combinationally in the same cycle it is presented, so the translation can be resolved while the cache reads its tag ways. The answer carries a hit indication, the physical frame number and the cached permission flags.

On a hit the requested access (load, store or instruction fetch) and the privilege level are checked against the cached flags. A violation raises a protection fault and withholds the frame number. On a miss the block raises a request to the page walker. The walker later presents the resolved entry on the fill port, and the block installs it.

Storage is 16 entries, 8 ways in each of 2 sets. The least significant bit of the virtual page number selects the set. A one-cycle flush invalidates every entry.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports miss_o=1 and hit_o=0.
- R2: A lookup with lookup_vld_i=1 that matches a valid entry reports hit_o=1 in the same cycle. It also returns that entry's frame on pfn_o and its flags on flags_o. The flag encoding is bit0 readable, bit1 writeable, bit2 executable, bit3 kernel-only.
- R3: Set selection uses VPN bit 0 and the tag is VPN bits 18:1. Pages that differ only in bit 0 occupy different sets and never evict each other.
- R4: Each set replaces round-robin. The ninth distinct fill into a set evicts the entry filled first, and the other entries stay present.
- R5: A fill whose tag is already present in its set overwrites that way in place. The round-robin pointer does not advance, so the next new fill goes to the way that pointer already held.
- R6: A hit with access_i=00 (load), or access_i=11 (treated as a load), on an entry whose readable flag is clear raises fault_o=1 with pfn_o=0. The walker request miss_o stays 0.
- R7: A hit with access_i=01 (store) on an entry whose writeable flag is clear raises fault_o=1 with pfn_o=0.
- R8: A hit with access_i=10 (fetch) on an entry whose executable flag is clear raises fault_o=1 with pfn_o=0.
- R9: A hit with user_i=1 on a kernel-only entry raises fault_o=1. The same access with user_i=0 does not.
- R10: flush_i=1 invalidates every entry at the next clock edge, so all lookups miss from the following cycle.
- R11: miss_o is 1 exactly when lookup_vld_i=1 and no entry matches. With lookup_vld_i=0, hit_o, miss_o, fault_o, pfn_o and flags_o are all 0.
- R12: When flush_i and fill_vld_i are high in the same cycle, the flush wins and the fill is not installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_vld_i | input | 1 | Lookup request |
| lookup_vpn_i | input | 19 | Virtual page number to translate |
| access_i | input | 2 | 00 load, 01 store, 10 fetch, 11 load |
| user_i | input | 1 | 1 = user mode, 0 = supervisor |
| hit_o | output | 1 | Matching valid entry found |
| miss_o | output | 1 | Request to page walker |
| fault_o | output | 1 | Protection violation on a hit |
| pfn_o | output | 15 | Physical frame number, 0 on miss or fault |
| flags_o | output | 4 | Cached flags of the hit entry |
| fill_vld_i | input | 1 | Install entry from walker |
| fill_vpn_i | input | 19 | Page number of the entry to install |
| fill_pfn_i | input | 15 | Frame number of the entry to install |
| fill_flags_i | input | 4 | Flags of the entry to install |
| flush_i | input | 1 | Invalidate all entries |

## Verification
Lookup results are combinational, so they are due in the same cycle the lookup inputs are applied. Fills and flushes change state only at the next rising edge, so they become visible one cycle after they are driven. The bench applies each lookup at a falling edge and pushes its expected result into a queue. A monitor pops the item a quarter period later and compares it, which keeps every comparison clear of the rising edge where state updates. Each fill or flush is held across exactly one rising edge before any lookup that depends on it is issued.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;
  localparam int FLAG_W = 4;
  localparam int FL_RD  = 0;
  localparam int FL_WR  = 1;
  localparam int FL_EX  = 2;
  localparam int FL_KO  = 3;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 18,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
  input  logic [TAG_W-1:0]            tag_i,
  output logic [WAYS-1:0]             match_o,
  output logic                        hit_o,
  output logic [WAY_W-1:0]            way_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_o[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  always_comb begin
    way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match_o[w]) way_o = WAY_W'(w);
    end
  end

  assign hit_o = |match_o;
endmodule

// File: rtl/tlb_perm_chk.sv
module tlb_perm_chk
  import tlb_xlate_pkg::*;
(
  input  logic              hit_i,
  input  logic [1:0]        access_i,
  input  logic              user_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              fault_o
);
  logic allowed;

  always_comb begin
    unique case (acc_e'(access_i))
      ACC_STORE: allowed = flags_i[FL_WR];
      ACC_FETCH: allowed = flags_i[FL_EX];
      default:   allowed = flags_i[FL_RD];
    endcase
    fault_o = hit_i && (!allowed || (user_i && flags_i[FL_KO]));
  end
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int SETS  = 2,
  parameter int WAYS  = 8,
  parameter int SET_W = $clog2(SETS),
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        adv_i,
  input  logic [SET_W-1:0]            set_i,
  output logic [SETS-1:0][WAY_W-1:0]  ptr_o
);
  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_o[s] <= '0;
      end else if (adv_i && (set_i == SET_W'(s))) begin
        ptr_o[s] <= (ptr_o[s] == WAY_W'(WAYS-1)) ? '0 : ptr_o[s] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_xlate_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 28,
  parameter int PAGE_W = 13,
  parameter int WAYS   = 8,
  parameter int SETS   = 2,
  parameter int VPN_W  = VA_W - PAGE_W,
  parameter int PFN_W  = PA_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_vld_i,
  input  logic [VPN_W-1:0]  lookup_vpn_i,
  input  logic [1:0]        access_i,
  input  logic              user_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic              fault_o,
  output logic [PFN_W-1:0]  pfn_o,
  output logic [FLAG_W-1:0] flags_o,
  input  logic              fill_vld_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic [FLAG_W-1:0] fill_flags_i,
  input  logic              flush_i
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = VPN_W - SET_W;

  logic [SETS-1:0][WAYS-1:0]              valid_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]   tag_q;
  logic [SETS-1:0][WAYS-1:0][PFN_W-1:0]   pfn_q;
  logic [SETS-1:0][WAYS-1:0][FLAG_W-1:0]  flags_q;

  // lookup path
  logic [SET_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;
  logic [WAYS-1:0]  lk_match;
  logic             lk_any;
  logic [WAY_W-1:0] lk_way;
  logic             lk_hit;
  logic             lk_fault;
  logic [FLAG_W-1:0] lk_flags;

  assign lk_set = lookup_vpn_i[SET_W-1:0];
  assign lk_tag = lookup_vpn_i[VPN_W-1:SET_W];

  tlb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .valid_i (valid_q[lk_set]),
    .tags_i  (tag_q[lk_set]),
    .tag_i   (lk_tag),
    .match_o (lk_match),
    .hit_o   (lk_any),
    .way_o   (lk_way)
  );

  assign lk_hit   = lookup_vld_i && lk_any;
  assign lk_flags = lk_hit ? flags_q[lk_set][lk_way] : '0;

  tlb_perm_chk u_perm (
    .hit_i    (lk_hit),
    .access_i (access_i),
    .user_i   (user_i),
    .flags_i  (lk_flags),
    .fault_o  (lk_fault)
  );

  assign hit_o   = lk_hit;
  assign miss_o  = lookup_vld_i && !lk_any;
  assign fault_o = lk_fault;
  assign flags_o = lk_flags;
  assign pfn_o   = (lk_hit && !lk_fault) ? pfn_q[lk_set][lk_way] : '0;

  // fill path
  logic [SET_W-1:0]         fl_set;
  logic [TAG_W-1:0]         fl_tag;
  logic [WAYS-1:0]          fl_match;
  logic                     fl_present;
  logic [WAY_W-1:0]         fl_hit_way;
  logic [WAY_W-1:0]         fl_way;
  logic [SETS-1:0][WAY_W-1:0] rr_ptr;
  logic                     fl_do;

  assign fl_set = fill_vpn_i[SET_W-1:0];
  assign fl_tag = fill_vpn_i[VPN_W-1:SET_W];
  assign fl_do  = fill_vld_i && !flush_i;

  tlb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fl_match (
    .valid_i (valid_q[fl_set]),
    .tags_i  (tag_q[fl_set]),
    .tag_i   (fl_tag),
    .match_o (fl_match),
    .hit_o   (fl_present),
    .way_o   (fl_hit_way)
  );

  // reuse an existing way for a tag already held, else take the victim pointer
  assign fl_way = fl_present ? fl_hit_way : rr_ptr[fl_set];

  tlb_rr_ptr #(.SETS(SETS), .WAYS(WAYS)) u_rr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (fl_do && !fl_present),
    .set_i  (fl_set),
    .ptr_o  (rr_ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else if (fl_do) begin
      valid_q[fl_set][fl_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fl_do) begin
      tag_q[fl_set][fl_way]   <= fl_tag;
      pfn_q[fl_set][fl_way]   <= fill_pfn_i;
      flags_q[fl_set][fl_way] <= fill_flags_i;
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int WAYS  = 8,
  parameter int PFN_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lookup_vld_i,
  input logic [1:0]       access_i,
  input logic             user_i,
  input logic             hit_o,
  input logic             miss_o,
  input logic             fault_o,
  input logic [PFN_W-1:0] pfn_o,
  input logic [3:0]       flags_o,
  input logic             flush_i,
  input logic [WAYS-1:0]  lk_match
);
  AST_HIT_MISS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_vld_i |-> !(hit_o || miss_o || fault_o)); // R11
  AST_FAULT_NO_PFN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (hit_o && pfn_o == '0 && !miss_o)); // R6
  AST_LOAD_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && (access_i == 2'b00) && !flags_o[0]) |-> fault_o); // R6
  AST_STORE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && (access_i == 2'b01) && !flags_o[1]) |-> fault_o); // R7
  AST_FETCH_NO_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && (access_i == 2'b10) && !flags_o[2]) |-> fault_o); // R8
  AST_USER_KERNEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && user_i && flags_o[3]) |-> fault_o); // R9
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !hit_o); // R10
  AST_NO_DUP_WAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match)); // R5
endmodule

bind tlb_xlate tlb_xlate_chk #(.WAYS(WAYS), .PFN_W(PFN_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lookup_vld_i (lookup_vld_i),
  .access_i     (access_i),
  .user_i       (user_i),
  .hit_o        (hit_o),
  .miss_o       (miss_o),
  .fault_o      (fault_o),
  .pfn_o        (pfn_o),
  .flags_o      (flags_o),
  .flush_i      (flush_i),
  .lk_match     (lk_match)
);

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic        hit;
    logic        miss;
    logic        fault;
    logic [14:0] pfn;
    logic [3:0]  flags;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lookup_vld = 1'b0;
  logic [18:0] lookup_vpn = '0;
  logic [1:0]  access = '0;
  logic        user = 1'b0;
  logic        hit, miss, fault;
  logic [14:0] pfn;
  logic [3:0]  flags;
  logic        fill_vld = 1'b0;
  logic [18:0] fill_vpn = '0;
  logic [14:0] fill_pfn = '0;
  logic [3:0]  fill_flags = '0;
  logic        flush = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_xlate uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .lookup_vld_i (lookup_vld),
    .lookup_vpn_i (lookup_vpn),
    .access_i     (access),
    .user_i       (user),
    .hit_o        (hit),
    .miss_o       (miss),
    .fault_o      (fault),
    .pfn_o        (pfn),
    .flags_o      (flags),
    .fill_vld_i   (fill_vld),
    .fill_vpn_i   (fill_vpn),
    .fill_pfn_i   (fill_pfn),
    .fill_flags_i (fill_flags),
    .flush_i      (flush)
  );

  localparam logic [3:0] RWX = 4'b0111;

  task automatic look(input logic [18:0] vpn, input logic [1:0] acc, input logic usr,
                      input logic ehit, input logic efault, input logic [14:0] epfn,
                      input logic [3:0] eflags, input string req);
    exp_t e;
    @(negedge clk);
    lookup_vld = 1'b1; lookup_vpn = vpn; access = acc; user = usr;
    e.hit = ehit; e.miss = !ehit; e.fault = efault;
    e.pfn = epfn; e.flags = eflags; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle_look(input logic [18:0] vpn, input string req);
    exp_t e;
    @(negedge clk);
    lookup_vld = 1'b0; lookup_vpn = vpn;
    e.hit = 0; e.miss = 0; e.fault = 0; e.pfn = '0; e.flags = '0; e.req = req;
    q.push_back(e);
  endtask

  task automatic fill(input logic [18:0] vpn, input logic [14:0] p, input logic [3:0] f,
                      input logic fl);
    @(negedge clk);
    lookup_vld = 1'b0;
    fill_vld = 1'b1; fill_vpn = vpn; fill_pfn = p; fill_flags = f; flush = fl;
    @(negedge clk);
    fill_vld = 1'b0; flush = 1'b0;
  endtask

  // monitor: compares a quarter period after the driving edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (hit !== e.hit || miss !== e.miss || fault !== e.fault ||
            pfn !== e.pfn || flags !== e.flags) begin
          failures++;
          $display("FAIL %s actual hit=%b miss=%b fault=%b pfn=%h flags=%b expected hit=%b miss=%b fault=%b pfn=%h flags=%b",
                   e.req, hit, miss, fault, pfn, flags, e.hit, e.miss, e.fault, e.pfn, e.flags);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    look(19'h00005, 2'b00, 0, 0, 0, '0, '0, "R1 empty after reset");
    idle_look(19'h00005, "R11 idle outputs zero");

    // R2 basic fill/hit, R3 sets
    fill(19'h00010, 15'h1234, RWX, 0);
    look(19'h00010, 2'b00, 1, 1, 0, 15'h1234, RWX, "R2 hit after fill");
    look(19'h00011, 2'b00, 1, 0, 0, '0, '0, "R11 miss other set");
    fill(19'h00011, 15'h0abc, RWX, 0);
    look(19'h00011, 2'b10, 1, 1, 0, 15'h0abc, RWX, "R3 set1 entry");
    look(19'h00010, 2'b01, 1, 1, 0, 15'h1234, RWX, "R3 set0 entry kept");

    // R4 fill remaining seven ways of set 0, then a ninth
    for (int i = 2; i <= 8; i++) fill(19'(i*16), 15'(16'h0200 + i), RWX, 0);
    for (int i = 2; i <= 8; i++)
      look(19'(i*16), 2'b00, 0, 1, 0, 15'(16'h0200 + i), RWX, "R4 full set hits");
    look(19'h00010, 2'b00, 0, 1, 0, 15'h1234, RWX, "R4 first entry before eviction");
    fill(19'h00100, 15'h0999, RWX, 0);
    look(19'h00010, 2'b00, 0, 0, 0, '0, '0, "R4 oldest evicted");
    look(19'h00100, 2'b00, 0, 1, 0, 15'h0999, RWX, "R4 new entry hits");
    look(19'h00020, 2'b00, 0, 1, 0, 15'h0202, RWX, "R4 second entry kept");
    look(19'h00011, 2'b00, 0, 1, 0, 15'h0abc, RWX, "R3 other set untouched");

    // R5 refill of present tag, pointer must stay on way 1
    fill(19'h00020, 15'h7777, RWX, 0);
    look(19'h00020, 2'b00, 0, 1, 0, 15'h7777, RWX, "R5 overwrite in place");
    fill(19'h00200, 15'h0555, RWX, 0);
    look(19'h00020, 2'b00, 0, 0, 0, '0, '0, "R5 pointer not advanced victim");
    look(19'h00030, 2'b00, 0, 1, 0, 15'h0203, RWX, "R5 next way kept");
    look(19'h00200, 2'b00, 0, 1, 0, 15'h0555, RWX, "R5 new entry");

    // permission cases in set 1
    fill(19'h01001, 15'h0101, 4'b0001, 0);
    look(19'h01001, 2'b00, 1, 1, 0, 15'h0101, 4'b0001, "R6 load readable ok");
    look(19'h01001, 2'b01, 1, 1, 1, '0, 4'b0001, "R7 store not writeable");
    look(19'h01001, 2'b10, 1, 1, 1, '0, 4'b0001, "R8 fetch not executable");
    fill(19'h01003, 15'h0103, 4'b1001, 0);
    look(19'h01003, 2'b00, 1, 1, 1, '0, 4'b1001, "R9 user on kernel page");
    look(19'h01003, 2'b00, 0, 1, 0, 15'h0103, 4'b1001, "R9 supervisor on kernel page");
    fill(19'h01005, 15'h0105, 4'b0110, 0);
    look(19'h01005, 2'b00, 0, 1, 1, '0, 4'b0110, "R6 load not readable");
    look(19'h01005, 2'b11, 0, 1, 1, '0, 4'b0110, "R6 code 11 acts as load");
    look(19'h01005, 2'b01, 0, 1, 0, 15'h0105, 4'b0110, "R7 store writeable ok");
    look(19'h01005, 2'b10, 0, 1, 0, 15'h0105, 4'b0110, "R8 fetch executable ok");

    // R10/R12 flush with simultaneous fill
    fill(19'h03003, 15'h0333, RWX, 1);
    look(19'h00011, 2'b00, 0, 0, 0, '0, '0, "R10 set1 flushed");
    look(19'h00030, 2'b00, 0, 0, 0, '0, '0, "R10 set0 flushed");
    look(19'h03003, 2'b00, 0, 0, 0, '0, '0, "R12 fill dropped on flush");
    fill(19'h03003, 15'h0333, RWX, 0);
    look(19'h03003, 2'b00, 0, 1, 0, 15'h0333, RWX, "R2 fill after flush");

    @(negedge clk);
    lookup_vld = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule